// File: doc/BRIEF.md
# Watchdog Timer with Cascaded Clock Divider

This block is a watchdog peripheral on a small register bus. The system clock passes through two stages before it reaches a 16-bit down-counter. The first stage is an 8-bit programmable prescaler that divides by its value plus one. The second stage is a fixed divider that divides by 16, 32, 64 or 128. Each output tick of the second stage steps the counter. When a tick finds the counter already at zero, the timer expires and reloads itself from a separate reload register. An expiry can raise a one-cycle interrupt pulse, a reset pulse several cycles wide, both or neither.

Software keeps the system alive by writing the live count register before it expires. Software stops the timer by clearing the run bit. While the timer is stopped, the reload value and the settings can be changed. When the run bit goes from 0 to 1, the live count is reloaded from the reload register. Reads return the live count and the stored settings. Bits that have no function read as zero.

Top module: `wdt_timer`

## Requirements
- R1: After reset the settings register reads 0x8039 (running, reset output enabled, interrupt disabled, divide by 128, prescale field 0x80). The reload register and the count register both read 0x8000.
- R2: The bus decodes three byte addresses: settings at 0x0, reload at 0x4 and live count at 0x8. The settings fields are: bit 0 reset enable, bit 2 interrupt enable, bits [4:3] divider select (0:/16, 1:/32, 2:/64, 3:/128), bit 5 run, bits [15:8] prescale. Writing all ones to the settings register reads back 0xFF3D. Every other address reads 0 and ignores writes.
- R3: A write to the settings register that sets the run bit from 0 is called the start write. With prescale field p, divider d and reload value r, the first expiry appears (r+1)·(p+1)·d clocks after the start write. Later expiries follow at the same interval.
- R4: A write to the count register loads the live counter at that clock edge. It reads back the written value in the next cycle.
- R5: While the run bit is clear, the live count holds its value and no interrupt or reset pulse is produced.
- R6: The start write loads the live count from the reload register, whatever value the count held before.
- R7: Each expiry with interrupt enable set gives an interrupt pulse exactly one clock wide, visible in the cycle after the expiring tick. With interrupt enable clear, expiries give no pulse.
- R8: Each expiry with reset enable set drives the reset output high for RST_PULSE clocks (8 by default). With reset enable clear, expiries do not drive the reset output.
- R9: A count write in the same cycle as an expiring tick wins. No interrupt or reset pulse is issued, and the counter takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the prescaler input |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| irq_pulse | output | 1 | One-clock expiry interrupt |
| sys_rst_out | output | 1 | Expiry reset pulse, active high |

## Verification
A keep-alive write to the count register can land in the same clock as the tick that would expire the timer. To make this happen, the bench sets the reload to zero so that every tick expires, with the prescale field at 0 and the divider at /16. It then times a count write so that it takes effect exactly 16 edges after the start write. The collision is judged correct if no interrupt appears after that edge and the next pulse comes a full (written value + 1) ticks later. A second collision is the start write meeting a stale count value, and it is judged by reading the count straight after the start write.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int PRE_W = 8;
  localparam int DIVC_W = 7;

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic             run;
    logic [1:0]       div_sel;
    logic             irq_en;
    logic             rst_en;
  } wdt_ctrl_t;

  // bit layout on the bus: [15:8] pre, [5] run, [4:3] div, [2] irq, [0] rst
  function automatic logic [15:0] ctrl_to_word(wdt_ctrl_t c);
    return {c.pre, 2'b00, c.run, c.div_sel, c.irq_en, 1'b0, c.rst_en};
  endfunction

  function automatic wdt_ctrl_t word_to_ctrl(logic [15:0] w);
    wdt_ctrl_t c;
    c.pre     = w[15:8];
    c.run     = w[5];
    c.div_sel = w[4:3];
    c.irq_en  = w[2];
    c.rst_en  = w[0];
    return c;
  endfunction

  localparam logic [15:0] CTRL_RESET = 16'h8039;

endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             srst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] pre,
  input  logic [1:0]       div_sel,
  output logic             tick
);
  logic [PRE_W-1:0]  pc_q, pc_d;
  logic [DIVC_W-1:0] dc_q, dc_d;
  logic [DIVC_W-1:0] div_lim;
  logic              pre_hit, div_hit;

  always_comb begin
    case (div_sel)
      2'd0:    div_lim = 7'd15;
      2'd1:    div_lim = 7'd31;
      2'd2:    div_lim = 7'd63;
      default: div_lim = 7'd127;
    endcase
  end

  always_comb begin
    pre_hit = (pc_q >= pre);
    div_hit = (dc_q == div_lim);
    tick    = run && pre_hit && div_hit;
    pc_d    = pc_q;
    dc_d    = dc_q;
    if (!run) begin
      pc_d = '0;
      dc_d = '0;
    end else if (pre_hit) begin
      pc_d = '0;
      dc_d = div_hit ? '0 : dc_q + DIVC_W'(1);
    end else begin
      pc_d = pc_q + PRE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      pc_q <= '0;
      dc_q <= '0;
    end else begin
      pc_q <= pc_d;
      dc_q <= dc_d;
    end
  end
endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
  parameter int CNT_W     = 16,
  parameter int RST_PULSE = 8
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic             tick,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] wr_val,
  input  logic             start,
  input  logic [CNT_W-1:0] reload,
  input  logic             irq_en,
  input  logic             rst_en,
  output logic [CNT_W-1:0] cnt,
  output logic             expire,
  output logic             irq_pulse,
  output logic             sys_rst_out
);
  localparam int RP_W = $clog2(RST_PULSE + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [RP_W-1:0]  rp_q, rp_d;
  logic             irq_q, irq_d;

  always_comb begin
    expire = tick && (cnt_q == '0) && !cnt_wr && !start;
    cnt_d  = cnt_q;
    if (cnt_wr)      cnt_d = wr_val;
    else if (start)  cnt_d = reload;
    else if (tick)   cnt_d = (cnt_q == '0) ? reload : cnt_q - CNT_W'(1);

    irq_d = expire && irq_en;

    if (expire && rst_en) rp_d = RP_W'(RST_PULSE);
    else if (rp_q != '0)  rp_d = rp_q - RP_W'(1);
    else                  rp_d = rp_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      cnt_q <= CNT_W'(16'h8000);
      rp_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rp_q  <= rp_d;
      irq_q <= irq_d;
    end
  end

  assign cnt         = cnt_q;
  assign irq_pulse   = irq_q;
  assign sys_rst_out = (rp_q != '0);
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int CNT_W     = 16,
  parameter int RST_PULSE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              irq_pulse,
  output logic              sys_rst_out
);
  localparam logic [ADDR_W-1:0] OFF_CTRL = ADDR_W'(4'h0);
  localparam logic [ADDR_W-1:0] OFF_RELD = ADDR_W'(4'h4);
  localparam logic [ADDR_W-1:0] OFF_CNT  = ADDR_W'(4'h8);

  logic             srst_n;
  wdt_ctrl_t        ctrl_q, ctrl_d;
  logic [CNT_W-1:0] reload_q, reload_d;
  logic             ctrl_wr, reld_wr, cnt_wr, start;
  logic             tick, expire;
  logic [CNT_W-1:0] cnt;

  wdt_rst_sync u_sync (.clk(clk), .rst_n(rst_n), .srst_n(srst_n));

  always_comb begin
    ctrl_wr  = bus_we && (bus_addr == OFF_CTRL);
    reld_wr  = bus_we && (bus_addr == OFF_RELD);
    cnt_wr   = bus_we && (bus_addr == OFF_CNT);
    start    = ctrl_wr && bus_wdata[5] && !ctrl_q.run;
    ctrl_d   = ctrl_wr ? word_to_ctrl(bus_wdata) : ctrl_q;
    reload_d = reld_wr ? bus_wdata[CNT_W-1:0] : reload_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ctrl_q   <= word_to_ctrl(CTRL_RESET);
      reload_q <= CNT_W'(16'h8000);
    end else begin
      ctrl_q   <= ctrl_d;
      reload_q <= reload_d;
    end
  end

  wdt_tick_gen u_tick (
    .clk(clk), .srst_n(srst_n), .run(ctrl_q.run),
    .pre(ctrl_q.pre), .div_sel(ctrl_q.div_sel), .tick(tick)
  );

  wdt_core #(.CNT_W(CNT_W), .RST_PULSE(RST_PULSE)) u_core (
    .clk(clk), .srst_n(srst_n), .tick(tick), .cnt_wr(cnt_wr),
    .wr_val(bus_wdata[CNT_W-1:0]), .start(start), .reload(reload_q),
    .irq_en(ctrl_q.irq_en), .rst_en(ctrl_q.rst_en), .cnt(cnt),
    .expire(expire), .irq_pulse(irq_pulse), .sys_rst_out(sys_rst_out)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == OFF_CTRL)      bus_rdata = ctrl_to_word(ctrl_q);
    else if (bus_addr == OFF_RELD) bus_rdata[CNT_W-1:0] = reload_q;
    else if (bus_addr == OFF_CNT)  bus_rdata[CNT_W-1:0] = cnt;
  end
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             srst_n,
  input logic             run,
  input logic             start,
  input logic             ctrl_wr,
  input logic             cnt_wr,
  input logic [CNT_W-1:0] wr_val,
  input logic [CNT_W-1:0] reload,
  input logic [CNT_W-1:0] cnt,
  input logic             tick,
  input logic             expire,
  input logic             irq_en,
  input logic             rst_en,
  input logic             irq,
  input logic             sys_rst
);
  assert_tick_needs_run_R3: assert property (@(posedge clk) disable iff (!srst_n)
    tick |-> run);

  assert_keepalive_load_R4: assert property (@(posedge clk) disable iff (!srst_n)
    cnt_wr |=> (cnt == $past(wr_val)));

  assert_stopped_hold_R5: assert property (@(posedge clk) disable iff (!srst_n)
    (!run && !cnt_wr && !ctrl_wr) |=> $stable(cnt));

  assert_start_reload_R6: assert property (@(posedge clk) disable iff (!srst_n)
    start |=> (cnt == $past(reload)));

  assert_irq_one_cycle_R7: assert property (@(posedge clk) disable iff (!srst_n)
    irq |=> !irq);

  assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!srst_n)
    irq |-> $past(irq_en));

  assert_rst_follows_R8: assert property (@(posedge clk) disable iff (!srst_n)
    (expire && rst_en) |=> sys_rst);

  assert_write_beats_expiry_R9: assert property (@(posedge clk) disable iff (!srst_n)
    cnt_wr |=> !irq);
endmodule

bind wdt_timer wdt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .srst_n(srst_n), .run(ctrl_q.run), .start(start),
  .ctrl_wr(ctrl_wr), .cnt_wr(cnt_wr), .wr_val(bus_wdata[CNT_W-1:0]),
  .reload(reload_q), .cnt(cnt), .tick(tick), .expire(expire),
  .irq_en(ctrl_q.irq_en), .rst_en(ctrl_q.rst_en), .irq(irq_pulse),
  .sys_rst(sys_rst_out)
);

// File: tb/tb_wdt_timer.sv
`timescale 1ns/1ps
module tb_wdt_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  bus_addr;
  logic        bus_we;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        irq_pulse;
  logic        sys_rst_out;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  wdt_timer dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_pulse(irq_pulse), .sys_rst_out(sys_rst_out)
  );

  function automatic logic [15:0] mk(bit run, bit ie, bit re, int dv, int pre);
    return {pre[7:0], 2'b00, run, dv[1:0], ie, 1'b0, re};
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the write edge
  task automatic wr(logic [3:0] a, logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output int v);
    bus_addr = a;
    #1;
    v = int'(bus_rdata);
  endtask

  // counts edges until irq seen at a negedge
  task automatic wait_irq(output int n);
    n = 0;
    do begin
      @(posedge clk); @(negedge clk); n++;
    end while (!irq_pulse && n < 5000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v, n, hi;
    bit seen;
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset contents
    rd(4'h0, v); check("R1 ctrl", v, 16'h8039);
    rd(4'h4, v); check("R1 reload", v, 16'h8000);
    rd(4'h8, v); check("R1 count", v, 16'h8000);

    // R2 map and masks
    wr(4'h0, 16'hFFFF); rd(4'h0, v); check("R2 ctrl mask", v, 16'hFF3D);
    wr(4'h0, 16'h0000);
    wr(4'h4, 16'hFFFF); rd(4'h4, v); check("R2 reload", v, 16'hFFFF);
    wr(4'hC, 16'h1234); rd(4'hC, v); check("R2 unmapped", v, 0);
    rd(4'h2, v); check("R2 unaligned", v, 0);
    rd(4'h4, v); check("R2 reload untouched", v, 16'hFFFF);

    // R3 / R7 sweep over divider, prescale and reload
    for (int dv = 0; dv < 4; dv++)
      for (int p = 0; p < 3; p++)
        for (int r = 0; r < 3; r++) begin
          int per;
          per = (r + 1) * (p + 1) * (16 << dv);
          wr(4'h0, mk(0, 1, 0, dv, p));
          wr(4'h4, 16'(r));
          wr(4'h0, mk(1, 1, 0, dv, p));
          wait_irq(n); check("R3 first expiry", n, per);
          @(negedge clk); check("R7 irq width", int'(irq_pulse), 0);
          wait_irq(n); check("R3 repeat expiry", n + 1, per);
        end

    // R5 stopped timer holds
    wr(4'h0, mk(0, 1, 1, 0, 0));
    rd(4'h8, v);
    seen = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk); if (irq_pulse || sys_rst_out) seen = 1;
    end
    rd(4'h8, n); check("R5 count held", n, v);
    check("R5 no events", int'(seen), 0);

    // R4 keep-alive and R6 restart
    wr(4'h4, 16'd9);
    wr(4'h8, 16'd5); rd(4'h8, v); check("R4 count write", v, 5);
    wr(4'h0, mk(1, 1, 0, 0, 0)); rd(4'h8, v); check("R6 start reload", v, 9);
    wr(4'h8, 16'hABCD); rd(4'h8, v); check("R4 running write", v, 16'hABCD);

    // R7 interrupt disabled, R8 reset disabled
    wr(4'h0, mk(0, 0, 0, 0, 0)); wr(4'h4, 16'd0);
    wr(4'h0, mk(1, 0, 0, 0, 0));
    seen = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk); if (irq_pulse || sys_rst_out) seen = 1;
    end
    check("R7/R8 gated off", int'(seen), 0);

    // R8 reset pulse width
    wr(4'h0, mk(0, 0, 0, 0, 0));
    wr(4'h0, mk(1, 0, 1, 0, 0));
    n = 0;
    do begin @(posedge clk); @(negedge clk); n++; end
    while (!sys_rst_out && n < 5000);
    check("R8 reset delay", n, 16);
    hi = 0;
    while (sys_rst_out && hi < 100) begin hi++; @(negedge clk); end
    check("R8 reset width", hi, 8);

    // R9 keep-alive on the expiring edge
    wr(4'h0, mk(0, 1, 0, 0, 0));
    wr(4'h0, mk(1, 1, 0, 0, 0));
    repeat (15) @(posedge clk);
    @(negedge clk);
    wr(4'h8, 16'd3);
    check("R9 no irq on collision", int'(irq_pulse), 0);
    wait_irq(n); check("R9 next expiry", n, 64);
    wr(4'h0, mk(0, 0, 0, 0, 0));

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule